// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine

This block is the bus-master half of a disk-style controller. Software programs three registers: a pointer to a table of region descriptors in memory, a command register, and a status register. The device side computes how many bytes the pending disk command will move and presents that count on `xfer_len`. Setting the start bit launches the transfer.

On start, the engine walks the descriptor table and fetches each 8-byte entry through a simple request/ready memory port. It then moves 32-bit words, either from the device buffer into memory or from memory into the device buffer. The direction bit of the command register selects which. When the byte count is used up, or the table runs out first, the engine drops its active flag, clears start and raises a level interrupt. That interrupt is mirrored in a status bit.

The intended programming order is: write the table pointer, let the device accept its command, then set start. A transfer in flight cannot be aborted from the register side.

Top module: `bm_dma_engine`

## Requirements
- R1: After reset, the command, status and pointer registers read 0, `irq` is low and `mem_req` is low.
- R2: Register map on `reg_addr`, read combinationally on `reg_rdata`:
  - 0 is the command register: bit 0 is start, bit 3 is direction.
  - 1 is the status register: bit 0 active, bit 1 error, bit 2 interrupt, bits 6:5 free for software, all other bits 0.
  - 2 is the table pointer: bits 1:0 read 0.
  - 3 reads 0.
- R3: A command write with bit 0 = 1 while idle sets active. The engine then fetches the descriptor at pointer + 8 × table index, word 0 first, then word 1.
- R4: A command write with bit 0 = 0 while idle resets the table index to 0. A new start issued without such a write continues with the descriptor after the last one consumed.
- R5: With direction = 1, each word is taken from the device with `dev_pop` and written to memory (`mem_we` = 1). With direction = 0, each word is read from memory and handed to the device with `dev_push`. Addresses advance by 4 from the descriptor base.
- R6: Descriptor format: word 0 is the base address. In word 1, bits 15:0 are the byte count (a multiple of 4, with 0 meaning 65536) and bit 31 marks end of table. Descriptors are used in order. `xfer_len` is latched at start, and the transfer stops once that many bytes have moved, even in the middle of a descriptor.
- R7: On completion, start and active clear. One cycle later the interrupt status bit sets, and `irq` follows that bit.
- R8: If the end-of-table descriptor is exhausted while bytes remain, the error status bit sets and completion proceeds as in R7.
- R9: While active, writes to the command and pointer registers have no effect.
- R10: A one-byte status write affects bits as follows:
  - Bits 6:5 take the written value.
  - Bit 0 is unaffected.
  - Bits 1 and 2 are cleared only where a 1 is written.
- R11: A status write with `reg_wide` = 1 changes nothing and pulses `reg_rej` high in the following cycle.
- R12: A memory request holds its address and type until `mem_ready`. The engine has one request outstanding at a time, and read data is taken on `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | Access is wider than one byte |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| reg_rej | output | 1 | Previous status write was rejected |
| xfer_len | input | LEN_W | Byte count from the device, latched at start |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of request |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| dev_pop | output | 1 | Take one word from the device |
| dev_rd_data | input | 32 | Head word of the device source |
| dev_push | output | 1 | Hand one word to the device |
| dev_wr_data | output | 32 | Word handed to the device |
| irq | output | 1 | Completion interrupt, level |

## Verification
A table index that is wrong inside the engine shows up at the very first descriptor fetch of the next start, as a wrong `mem_addr` on the request bus. A wrong remaining-byte or segment count shows up on the first data word, either as an extra word, a missing word or a wrong address. A status register that mixes up its preserve, write-through and clear-on-one rules is visible on the register read that immediately follows the write. A lost completion is caught because `irq` never rises.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;

   localparam int WORD_W     = 32;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int DESC_BYTES = 8;
   localparam int EOT_BIT    = 31;

   localparam logic [1:0] RA_CMD  = 2'd0;
   localparam logic [1:0] RA_STAT = 2'd1;
   localparam logic [1:0] RA_PTR  = 2'd2;

   localparam int CMD_GO  = 0;
   localparam int CMD_DIR = 3;

   localparam int ST_ACT = 0;
   localparam int ST_ERR = 1;
   localparam int ST_INT = 2;
   localparam int ST_SW0 = 5;
   localparam int ST_SW1 = 6;

   typedef enum logic [3:0] {
      W_IDLE,
      W_MOVE,
      W_D0_REQ,
      W_D0_WAIT,
      W_D1_REQ,
      W_D1_WAIT,
      W_WR_REQ,
      W_RD_REQ,
      W_RD_WAIT,
      W_FIN
   } walk_state_e;

endpackage

// File: rtl/bm_regs.sv
module bm_regs
   import bm_dma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_wide,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_rej,
   input  logic              fin,
   input  logic              fin_err,
   output logic              go,
   output logic              go_dir,
   output logic              clr_idx,
   output logic [ADDR_W-1:0] tbl_ptr,
   output logic              active,
   output logic              irq
);

   logic              start_q, dir_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              act_q, err_q, int_q, pend_q;
   logic [1:0]        sw_q;
   logic              cmd_wr, ptr_wr, stat_wr;
   logic [7:0]        status;

   assign cmd_wr  = reg_wr && (reg_addr == RA_CMD) && !act_q;
   assign ptr_wr  = reg_wr && (reg_addr == RA_PTR) && !act_q;
   assign stat_wr = reg_wr && (reg_addr == RA_STAT) && !reg_wide;

   assign go      = cmd_wr && reg_wdata[CMD_GO];
   assign clr_idx = cmd_wr && !reg_wdata[CMD_GO];
   assign go_dir  = reg_wdata[CMD_DIR];
   assign tbl_ptr = ptr_q;
   assign active  = act_q;
   assign irq     = int_q;

   assign status = {1'b0, sw_q, 2'b00, int_q, err_q, act_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         dir_q   <= 1'b0;
         ptr_q   <= '0;
         act_q   <= 1'b0;
         err_q   <= 1'b0;
         int_q   <= 1'b0;
         pend_q  <= 1'b0;
         sw_q    <= 2'b00;
         reg_rej <= 1'b0;
      end else begin
         pend_q  <= fin;
         reg_rej <= reg_wr && (reg_addr == RA_STAT) && reg_wide;
         if (cmd_wr) begin
            start_q <= reg_wdata[CMD_GO];
            dir_q   <= reg_wdata[CMD_DIR];
            if (reg_wdata[CMD_GO])
               act_q <= 1'b1;
         end
         if (ptr_wr)
            ptr_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
         if (stat_wr) begin
            sw_q <= reg_wdata[ST_SW1:ST_SW0];
            if (reg_wdata[ST_ERR]) err_q <= 1'b0;
            if (reg_wdata[ST_INT]) int_q <= 1'b0;
         end
         if (fin) begin
            act_q   <= 1'b0;
            start_q <= 1'b0;
            if (fin_err)
               err_q <= 1'b1;
         end
         if (pend_q)
            int_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CMD:  reg_rdata = {28'd0, dir_q, 2'b00, start_q};
         RA_STAT: reg_rdata = {24'd0, status};
         RA_PTR:  reg_rdata = {{(32-ADDR_W){1'b0}}, ptr_q};
         default: reg_rdata = '0;
      endcase
   end

   // R7
   act_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_q) |-> $past(fin));

   // R7
   irq_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_q) |-> !act_q);

   // R11
   wide_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rej |-> $stable(sw_q));

   // R9
   cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q && $past(act_q) |-> $stable(dir_q) && $stable(ptr_q));

endmodule

// File: rtl/bm_walker.sv
module bm_walker
   import bm_dma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 20,
   parameter int CNT_W     = 16,
   parameter int IDX_W     = 8,
   parameter bit ZERO_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_dir,
   input  logic              clr_idx,
   input  logic [ADDR_W-1:0] tbl_ptr,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              dev_pop,
   input  logic [WORD_W-1:0] dev_rd_data,
   output logic              dev_push,
   output logic [WORD_W-1:0] dev_wr_data,
   output logic              fin,
   output logic              fin_err
);

   localparam int SEG_W = CNT_W + 1;
   localparam logic [SEG_W-1:0]  SEG_STEP = SEG_W'(WORD_BYTES);
   localparam logic [LEN_W-1:0]  LEN_STEP = LEN_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] ADR_STEP = ADDR_W'(WORD_BYTES);

   walk_state_e       state;
   logic [IDX_W-1:0]  idx_q;
   logic [LEN_W-1:0]  rem_q;
   logic [SEG_W-1:0]  seg_q;
   logic [ADDR_W-1:0] base_q;
   logic              eot_q, dir_q, ferr_q;
   logic [WORD_W-1:0] wbuf_q;
   logic [ADDR_W-1:0] desc_addr;
   logic [SEG_W-1:0]  seg_load;
   logic [CNT_W-1:0]  cnt_field;
   logic              unused_desc;

   assign desc_addr = tbl_ptr + (ADDR_W'(idx_q) << 3);
   assign cnt_field = {mem_rdata[CNT_W-1:2], 2'b00};
   assign unused_desc = ^{mem_rdata[EOT_BIT-1:CNT_W], mem_rdata[1:0]};

   generate
      if (ZERO_FULL) begin : g_zero_full
         assign seg_load = (cnt_field == '0) ? {1'b1, {CNT_W{1'b0}}}
                                             : {1'b0, cnt_field};
      end else begin : g_zero_empty
         assign seg_load = {1'b0, cnt_field};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= W_IDLE;
         idx_q  <= '0;
         rem_q  <= '0;
         seg_q  <= '0;
         base_q <= '0;
         eot_q  <= 1'b0;
         dir_q  <= 1'b0;
         ferr_q <= 1'b0;
         wbuf_q <= '0;
      end else begin
         if (clr_idx)
            idx_q <= '0;
         case (state)
            W_IDLE: begin
               if (go) begin
                  dir_q  <= go_dir;
                  rem_q  <= xfer_len;
                  seg_q  <= '0;
                  eot_q  <= 1'b0;
                  ferr_q <= 1'b0;
                  state  <= W_MOVE;
               end
            end
            W_MOVE: begin
               if (rem_q == '0) begin
                  state <= W_FIN;
               end else if (seg_q == '0) begin
                  if (eot_q) begin
                     ferr_q <= 1'b1;
                     state  <= W_FIN;
                  end else begin
                     state <= W_D0_REQ;
                  end
               end else if (dir_q) begin
                  wbuf_q <= dev_rd_data;
                  state  <= W_WR_REQ;
               end else begin
                  state <= W_RD_REQ;
               end
            end
            W_D0_REQ:  if (mem_ready) state <= W_D0_WAIT;
            W_D0_WAIT: begin
               if (mem_rvalid) begin
                  base_q <= mem_rdata[ADDR_W-1:0];
                  state  <= W_D1_REQ;
               end
            end
            W_D1_REQ:  if (mem_ready) state <= W_D1_WAIT;
            W_D1_WAIT: begin
               if (mem_rvalid) begin
                  seg_q <= seg_load;
                  eot_q <= mem_rdata[EOT_BIT];
                  idx_q <= idx_q + 1'b1;
                  state <= W_MOVE;
               end
            end
            W_WR_REQ: begin
               if (mem_ready) begin
                  base_q <= base_q + ADR_STEP;
                  seg_q  <= seg_q - SEG_STEP;
                  rem_q  <= rem_q - LEN_STEP;
                  state  <= W_MOVE;
               end
            end
            W_RD_REQ:  if (mem_ready) state <= W_RD_WAIT;
            W_RD_WAIT: begin
               if (mem_rvalid) begin
                  base_q <= base_q + ADR_STEP;
                  seg_q  <= seg_q - SEG_STEP;
                  rem_q  <= rem_q - LEN_STEP;
                  state  <= W_MOVE;
               end
            end
            W_FIN:   state <= W_IDLE;
            default: state <= W_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = base_q;
      case (state)
         W_D0_REQ: begin mem_req = 1'b1; mem_addr = desc_addr; end
         W_D1_REQ: begin mem_req = 1'b1; mem_addr = desc_addr + ADR_STEP; end
         W_WR_REQ: begin mem_req = 1'b1; mem_we = 1'b1; end
         W_RD_REQ: mem_req = 1'b1;
         default:  mem_req = 1'b0;
      endcase
   end

   assign mem_wdata   = wbuf_q;
   assign dev_pop     = (state == W_MOVE) && (rem_q != '0) && (seg_q != '0) && dir_q;
   assign dev_push    = (state == W_RD_WAIT) && mem_rvalid;
   assign dev_wr_data = mem_rdata;
   assign fin         = (state == W_FIN);
   assign fin_err     = ferr_q;

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R5
   one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_pop && dev_push));

   // R6
   rem_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != W_IDLE) && ($past(state) != W_IDLE) |-> rem_q <= $past(rem_q));

endmodule

// File: rtl/bm_dma_engine.sv
module bm_dma_engine
   import bm_dma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 20,
   parameter int CNT_W     = 16,
   parameter int IDX_W     = 8,
   parameter bit ZERO_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_wide,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_rej,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ready,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              dev_pop,
   input  logic [31:0]       dev_rd_data,
   output logic              dev_push,
   output logic [31:0]       dev_wr_data,
   output logic              irq
);

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("bm_dma_engine: ADDR_W must lie in 8..32");
      end
      if (LEN_W < 3 || LEN_W > 31) begin : g_bad_len_w
         $error("bm_dma_engine: LEN_W must lie in 3..31");
      end
      if (CNT_W < 3 || CNT_W > 16) begin : g_bad_cnt_w
         $error("bm_dma_engine: CNT_W must lie in 3..16");
      end
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx_w
         $error("bm_dma_engine: IDX_W must lie in 1..16");
      end
   endgenerate

   logic              go, go_dir, clr_idx, active, fin, fin_err;
   logic [ADDR_W-1:0] tbl_ptr;

   bm_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_wide  (reg_wide),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .reg_rej   (reg_rej),
      .fin       (fin),
      .fin_err   (fin_err),
      .go        (go),
      .go_dir    (go_dir),
      .clr_idx   (clr_idx),
      .tbl_ptr   (tbl_ptr),
      .active    (active),
      .irq       (irq)
   );

   bm_walker #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .CNT_W     (CNT_W),
      .IDX_W     (IDX_W),
      .ZERO_FULL (ZERO_FULL)
   ) u_walker (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .go_dir      (go_dir),
      .clr_idx     (clr_idx),
      .tbl_ptr     (tbl_ptr),
      .xfer_len    (xfer_len),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_ready   (mem_ready),
      .mem_rvalid  (mem_rvalid),
      .mem_rdata   (mem_rdata),
      .dev_pop     (dev_pop),
      .dev_rd_data (dev_rd_data),
      .dev_push    (dev_push),
      .dev_wr_data (dev_wr_data),
      .fin         (fin),
      .fin_err     (fin_err)
   );

   // R3
   req_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> active);

   // R7
   fin_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> active);

endmodule

// File: tb/bm_dma_engine_bench.sv
module bm_dma_engine_bench;

   localparam int LEN_W = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_wide = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_rej;
   logic [LEN_W-1:0] xfer_len = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ready = 1'b1, mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        dev_pop, dev_push;
   logic [31:0] dev_rd_data = '0, dev_wr_data;
   logic        irq;

   always #5 clk = ~clk;

   bm_dma_engine u_bm_dma_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rej(reg_rej), .xfer_len(xfer_len), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .dev_pop(dev_pop), .dev_rd_data(dev_rd_data), .dev_push(dev_push),
      .dev_wr_data(dev_wr_data), .irq(irq)
   );

   logic [31:0] mem [int];
   logic [31:0] exp_wa[$], exp_wd[$], exp_push[$], src_q[$];
   int          n_chk = 0, n_bad = 0, cyc = 0, tbl_idx = 0;
   logic [31:0] ptr_m = '0, word_seed = 32'hA500_0000;
   bit          pend = 1'b0, stall_en = 1'b0, prev_stall = 1'b0;
   logic [31:0] pend_addr = '0, prev_addr = '0;

   function automatic logic [31:0] rdm(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'd0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // behavioural memory, device and per-clock comparison
   always @(negedge clk) begin
      cyc++;
      mem_ready  = stall_en ? ((cyc % 3) != 1) : 1'b1;
      mem_rvalid = pend;
      mem_rdata  = pend ? rdm(pend_addr) : 32'd0;
      pend       = 1'b0;
      dev_rd_data = (src_q.size() != 0) ? src_q[0] : 32'd0;
      #1;
      if (rst_n) begin
         if (prev_stall)
            chk(mem_req && mem_addr == prev_addr, "R12 request held", mem_addr, prev_addr);
         prev_stall = mem_req && !mem_ready;
         prev_addr  = mem_addr;
         if (mem_req && mem_ready) begin
            if (mem_we) begin
               if (exp_wa.size() == 0)
                  chk(1'b0, "R5 unexpected memory write", mem_addr, 32'd0);
               else begin
                  chk(mem_addr == exp_wa[0], "R5 write address", mem_addr, exp_wa[0]);
                  chk(mem_wdata == exp_wd[0], "R5 write data", mem_wdata, exp_wd[0]);
                  void'(exp_wa.pop_front());
                  void'(exp_wd.pop_front());
               end
               mem[mem_addr] = mem_wdata;
            end else begin
               pend = 1'b1;
               pend_addr = mem_addr;
            end
         end
         if (dev_pop && src_q.size() != 0)
            void'(src_q.pop_front());
         if (dev_push) begin
            if (exp_push.size() == 0)
               chk(1'b0, "R5 unexpected device push", dev_wr_data, 32'd0);
            else begin
               chk(dev_wr_data == exp_push[0], "R6 pushed word", dev_wr_data, exp_push[0]);
               void'(exp_push.pop_front());
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit wide);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = wide;
      @(negedge clk);
      reg_wr = 1'b0; reg_wide = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #2 v = reg_rdata;
   endtask

   // reference walk of the table: fills expectation queues
   task automatic plan(input bit to_mem, input int len, output bit err_exp);
      int rem = len;
      int seg = 0;
      bit eot = 1'b0;
      logic [31:0] b = '0, d1;
      err_exp = 1'b0;
      forever begin
         if (rem == 0) break;
         if (seg == 0) begin
            if (eot) begin err_exp = 1'b1; break; end
            b   = rdm(ptr_m + 32'(8 * tbl_idx));
            d1  = rdm(ptr_m + 32'(8 * tbl_idx) + 4);
            seg = (d1[15:0] == 16'd0) ? 65536 : int'(d1[15:0]);
            eot = d1[31];
            tbl_idx++;
         end else begin
            if (to_mem) begin
               word_seed = word_seed + 32'h0001_0203;
               src_q.push_back(word_seed);
               exp_wa.push_back(b);
               exp_wd.push_back(word_seed);
            end else begin
               exp_push.push_back(rdm(b));
            end
            b = b + 4; seg -= 4; rem -= 4;
         end
      end
   endtask

   task automatic start(input bit to_mem, input int len, output bit err_exp);
      plan(to_mem, len, err_exp);
      xfer_len = LEN_W'(len);
      wr(2'd0, {28'd0, to_mem, 3'b001}, 1'b0);
   endtask

   task automatic finish(input bit err_exp, input bit to_mem, input string tag);
      logic [31:0] v;
      int t = 0;
      while (!irq && t < 20000) begin @(negedge clk); t++; end
      chk(irq == 1'b1, {"R7 irq raised ", tag}, 32'(irq), 32'd1);
      rd(2'd1, v);
      chk(v[0] == 1'b0, {"R7 active cleared ", tag}, v, 32'd0);
      chk(v[2] == 1'b1, {"R7 interrupt bit ", tag}, v, 32'd4);
      chk(v[1] == err_exp, {"R8 error bit ", tag}, v, 32'(err_exp) << 1);
      rd(2'd0, v);
      chk(v == {28'd0, to_mem, 3'b000}, {"R7 start self-cleared ", tag}, v, {28'd0, to_mem, 3'b000});
      chk(exp_wa.size() == 0 && exp_push.size() == 0, {"R6 all words moved ", tag},
          32'(exp_wa.size() + exp_push.size()), 32'd0);
   endtask

   task automatic clear_int();
      logic [31:0] v;
      wr(2'd1, 32'h06, 1'b0);
      rd(2'd1, v);
      chk(v == 32'd0, "R10 clear by writing ones", v, 32'd0);
      chk(irq == 1'b0, "R7 irq follows interrupt bit", 32'(irq), 32'd0);
   endtask

   task automatic set_ptr(input logic [31:0] p);
      ptr_m = p;
      wr(2'd2, p, 1'b0);
   endtask

   task automatic clr_idx();
      wr(2'd0, 32'd0, 1'b0);
      tbl_idx = 0;
   endtask

   initial begin
      #1500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      bit e;
      // tables and data
      mem[32'h1000] = 32'h0000_4000; mem[32'h1004] = 32'h0000_0010;
      mem[32'h1008] = 32'h0000_4100; mem[32'h100C] = 32'h8000_000C;
      for (int i = 0; i < 16; i++) mem[32'h6000 + 32'(4*i)] = 32'hC0DE_0000 + 32'(i * 7);
      mem[32'h1100] = 32'h0000_6000; mem[32'h1104] = 32'h8000_0020;
      mem[32'h1200] = 32'h0000_7000; mem[32'h1204] = 32'h8000_0010;
      mem[32'h1300] = 32'h0000_6010; mem[32'h1304] = 32'h0000_0008;
      mem[32'h1308] = 32'h0000_6030; mem[32'h130C] = 32'h8000_0008;
      mem[32'h1400] = 32'h0000_8000; mem[32'h1404] = 32'h8000_0000;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R2 unused address
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 32'd0, "R1 R2 register reads zero after reset", v, 32'd0);
      end
      chk(irq == 1'b0 && mem_req == 1'b0, "R1 irq and mem_req low", {30'd0, irq, mem_req}, 32'd0);

      // R2 pointer low bits
      set_ptr(32'h1000);
      wr(2'd2, 32'h0000_1003, 1'b0);
      rd(2'd2, v);
      chk(v == 32'h1000, "R2 pointer bits 1:0 read zero", v, 32'h1000);

      // R3 R5 R6 device to memory over two descriptors
      clr_idx();
      start(1'b1, 28, e);
      rd(2'd1, v);
      chk(v[0] == 1'b1, "R3 active while running", v, 32'd1);
      finish(e, 1'b1, "dev-to-mem");
      clear_int();

      // R5 R6 memory to device, length shorter than descriptor, with stalls
      stall_en = 1'b1;
      set_ptr(32'h1100); clr_idx();
      start(1'b0, 8, e);
      finish(e, 1'b0, "short length");
      chk(e == 1'b0, "R6 early stop is not an error", 32'(e), 32'd0);
      clear_int();

      // R8 table exhausted
      set_ptr(32'h1200); clr_idx();
      start(1'b1, 40, e);
      finish(e, 1'b1, "table exhausted");
      chk(e == 1'b1, "R8 model predicts error", 32'(e), 32'd1);

      // R10 status write rules (error and interrupt both set now)
      wr(2'd1, 32'h62, 1'b0);
      rd(2'd1, v);
      chk(v == 32'h64, "R10 sw bits written, error cleared, int kept", v, 32'h64);
      wr(2'd1, 32'h05, 1'b0);
      rd(2'd1, v);
      chk(v == 32'h00, "R10 active not writable, int cleared", v, 32'h00);

      // R11 wide status write rejected
      wr(2'd1, 32'h60, 1'b1);
      #1 chk(reg_rej == 1'b1, "R11 reject pulse", 32'(reg_rej), 32'd1);
      rd(2'd1, v);
      chk(v == 32'h00, "R11 wide write changed nothing", v, 32'h00);
      chk(reg_rej == 1'b0, "R11 reject pulse is one cycle", 32'(reg_rej), 32'd0);

      // R4 continuation and index reset
      set_ptr(32'h1300); clr_idx();
      start(1'b0, 8, e); finish(e, 1'b0, "first of pair"); clear_int();
      start(1'b0, 8, e); finish(e, 1'b0, "continued index"); clear_int();
      clr_idx();
      start(1'b0, 8, e); finish(e, 1'b0, "after index reset"); clear_int();

      // R9 writes during a transfer are ignored
      set_ptr(32'h1100); clr_idx();
      start(1'b0, 24, e);
      wr(2'd0, 32'h08, 1'b0);
      wr(2'd2, 32'h0000_9000, 1'b0);
      finish(e, 1'b0, "writes while active");
      rd(2'd2, v);
      chk(v == 32'h1100, "R9 pointer unchanged", v, 32'h1100);
      clear_int();

      // R6 byte count zero means 65536
      stall_en = 1'b0;
      set_ptr(32'h1400); clr_idx();
      start(1'b1, 8, e);
      finish(e, 1'b1, "zero count");
      chk(e == 1'b0, "R6 zero count is full size", 32'(e), 32'd0);
      clear_int();

      repeat (5) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule